// File: doc/BRIEF.md
# SCSI DMA Channel Register Engine

This block is the register-side state of a bus-master DMA channel that sits between a host register port and a SCSI protocol core. It holds eight 32-bit words addressed by a 3-bit word index. Software programs a starting byte count, a starting memory address and a starting descriptor-list address. It then writes a command word whose two low bits pick one of four operations. A start operation copies the programmed values into working copies, clears the status flags and turns the engine on. An abort operation sends a one-cycle cancel pulse to the core. An idle operation turns the engine off. A burst-flush operation has no effect here.

While the engine moves data, the memory side offers transfers one at a time. Each offer carries a byte length and a direction. The block accepts an offer only when its direction matches the command's direction bit. It clips the offer to the remaining working count, lowers the count by the granted bytes and raises the working address by the same amount. A completion input from the core zeroes the working count and sets a sticky done flag. Two policies clear the sticky flags, chosen by a mode bit from the separate bus-control register: software writes ones to them, or a status read clears them after it returns their value.

Top module: `scsi_dma_chan`

## Requirements
- R1: After a synchronous reset, word 0 (command), word 3 (working count) and word 5 (status, with scsi_irq low) read 0. Word 4 (working address) reads 0xFFFFFFFF, word 7 (working list address) reads 0xFFFFFFFD, and engine_en is 0.
- R2: Words 1, 2 and 6 (start count, start address, start list address) and word 0 store the written value and read it back. Writes to words 3, 4 and 7 leave them unchanged.
- R3: A command write with low bits 0 (idle) clears engine_en in the next cycle. A command write with low bits 1 (burst flush) leaves engine_en and all other words unchanged.
- R4: A command write with low bits 2 (abort) raises abort_pulse for exactly the cycle after the write. It leaves engine_en unchanged. abort_pulse is 0 in every other cycle.
- R5: A command write with low bits 3 (start) loads word 3 from word 1, word 4 from word 2 and word 7 from word 6. It clears status bits 5:0 and sets engine_en.
- R6: With clr_on_read low, writing word 5 clears each of status bits 1 (error), 2 (abort) and 3 (done) whose written bit is 1. Other bits are unaffected, and a status read clears nothing.
- R7: With clr_on_read high, writes to word 5 are ignored. A read of word 5 returns the current value, and bits 1 to 3 are then clear from the next cycle.
- R8: A status read shows bit 4 set whenever scsi_irq is high, independent of the stored flags.
- R9: When a transfer is accepted, xfer_bytes equals the smaller of xfer_len and word 3. In the next cycle word 3 has dropped by xfer_bytes and word 4 has risen by xfer_bytes, modulo 2^32.
- R10: A transfer whose xfer_to_mem differs from command bit 7 (1 = device to memory) gives xfer_ok 0 and xfer_bytes 0, and changes neither word 3 nor word 4.
- R11: A cmd_done pulse sets word 3 to 0 and sets status bit 3 (done) in the next cycle. The done bit stays set until one of the clear policies removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read-clear) |
| reg_idx | input | 3 | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx, combinational |
| clr_on_read | input | 1 | Mode bit from the bus-control register: 1 = status clears on read |
| xfer_req | input | 1 | Transfer offer from the memory side |
| xfer_to_mem | input | 1 | Offer direction, 1 = device to memory |
| xfer_len | input | 16 | Offered byte length |
| xfer_ok | output | 1 | Offer accepted |
| xfer_bytes | output | 32 | Granted byte count, 0 when not accepted |
| cmd_done | input | 1 | Command-complete pulse from the SCSI core |
| scsi_irq | input | 1 | Interrupt level from the SCSI core |
| engine_en | output | 1 | Engine enable toward the SCSI core |
| abort_pulse | output | 1 | One-cycle cancel request to the SCSI core |

## Verification
The assertions assume that the register port and the transfer port are used one item per cycle. They also assume that cmd_done is a pulse and not a level, and that a rejected offer is judged in a cycle without a start or a completion. The stimulus respects these limits because each bench task drives a single register access, transfer offer or completion per cycle. Random lengths and programmed counts are kept in overlapping small ranges, so clipping to the working count, exhausted counts and zero-length offers all occur often. The direction bit and the clear-on-read mode are flipped at random.

// File: rtl/scsi_dma_pkg.sv
// Shared word indices, command operations and status bit positions for the
// DMA channel register engine. Assumes a 3-bit word index.
package scsi_dma_pkg;

    typedef enum logic [2:0] {
        RI_CMD  = 3'd0,
        RI_SCNT = 3'd1,
        RI_SADR = 3'd2,
        RI_WCNT = 3'd3,
        RI_WADR = 3'd4,
        RI_STAT = 3'd5,
        RI_SLST = 3'd6,
        RI_WLST = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    localparam int          CMD_DIR_BIT = 7;
    localparam int          STAT_W      = 6;
    localparam int          ST_DONE     = 3;
    localparam int          ST_IRQ      = 4;
    localparam logic [5:0]  ST_CLR_MASK = 6'b00_1110;

endpackage

// File: rtl/dma_cmd_ctl.sv
// Command word holder: stores the command, decodes its operation field and
// drives the engine enable and the abort pulse. Assumes at most one command
// write per cycle.
module dma_cmd_ctl
    import scsi_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic              start_ld,
    output logic              engine_en,
    output logic              abort_pulse
);

    dma_op_e op;

    // Operation field of the word being written.
    always_comb begin
        op       = dma_op_e'(wdata[1:0]);
        start_ld = cmd_wr && (op == OP_START);
    end

    // Command storage, enable tracking and abort pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            engine_en   <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= cmd_wr && (op == OP_ABORT);
            if (cmd_wr) begin
                cmd_q <= wdata;
                case (op)
                    OP_IDLE:  engine_en <= 1'b0;
                    OP_START: engine_en <= 1'b1;
                    default:  engine_en <= engine_en;
                endcase
            end
        end
    end

    AST_ABORT_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(cmd_wr && (wdata[1:0] == 2'd2))); // R4
    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        start_ld |=> engine_en); // R5
    AST_IDLE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (wdata[1:0] == 2'd0)) |=> !engine_en); // R3

endmodule

// File: rtl/dma_work_ctr.sv
// Working count, working address and working list address. Loads from the
// start copies on a start, clips each accepted transfer to the remaining
// count and zeroes the count on completion. Assumes LEN_W <= DATA_W.
module dma_work_ctr #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_cnt,
    input  logic [DATA_W-1:0] ld_adr,
    input  logic [DATA_W-1:0] ld_lst,
    input  logic              xfer_fire,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              cmd_done,
    output logic [DATA_W-1:0] wcnt,
    output logic [DATA_W-1:0] wadr,
    output logic [DATA_W-1:0] wlst,
    output logic [DATA_W-1:0] xfer_bytes
);

    localparam logic [DATA_W-1:0] WADR_RST = '1;
    localparam logic [DATA_W-1:0] WLST_RST = WADR_RST - DATA_W'(2);

    logic [DATA_W-1:0] len_ext;

    // Clip the offered length to what remains; zero when not accepted.
    always_comb begin
        len_ext    = DATA_W'(xfer_len);
        xfer_bytes = '0;
        if (xfer_fire)
            xfer_bytes = (len_ext < wcnt) ? len_ext : wcnt;
    end

    // Working register update: load, then transfer, then completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            wadr <= WADR_RST;
            wlst <= WLST_RST;
        end else begin
            if (load) begin
                wcnt <= ld_cnt;
                wadr <= ld_adr;
                wlst <= ld_lst;
            end else if (xfer_fire) begin
                wcnt <= wcnt - xfer_bytes;
                wadr <= wadr + xfer_bytes;
            end
            if (cmd_done)
                wcnt <= '0;
        end
    end

    AST_GRANT_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_bytes <= wcnt); // R9
    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> wcnt <= $past(wcnt)); // R9
    AST_DONE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> wcnt == '0); // R11

endmodule

// File: rtl/dma_status.sv
// Sticky status flags. A start clears all flags, software clears the error,
// abort and done flags by write-one or by read depending on the mode bit,
// and completion sets done. Set wins over clear in the same cycle.
module dma_status
    import scsi_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_clr,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    input  logic              st_rd,
    input  logic              clr_on_read,
    input  logic              set_done,
    output logic [STAT_W-1:0] stat_q
);

    logic [STAT_W-1:0] stat_d;

    // Next flag value from the clear and set sources in priority order.
    always_comb begin
        stat_d = stat_q;
        if (start_clr)
            stat_d = '0;
        if (st_wr && !clr_on_read)
            stat_d = stat_d & ~(st_wdata & ST_CLR_MASK);
        if (st_rd && clr_on_read)
            stat_d = stat_d & ~ST_CLR_MASK;
        if (set_done)
            stat_d[ST_DONE] = 1'b1;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> stat_q[3]); // R11
    AST_RO_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_read && st_wr && !st_rd && !start_clr && !set_done)
        |=> stat_q == $past(stat_q)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_read && st_rd && !set_done) |=> (stat_q & 6'b00_1110) == '0); // R7

endmodule

// File: rtl/scsi_dma_chan.sv
// Top of the DMA channel register engine: holds the start copies, decodes
// the register port, judges transfer direction and muxes read data.
// Assumes one register access per cycle and cmd_done given as a pulse.
module scsi_dma_chan
    import scsi_dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              clr_on_read,
    input  logic              xfer_req,
    input  logic              xfer_to_mem,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_ok,
    output logic [DATA_W-1:0] xfer_bytes,
    input  logic              cmd_done,
    input  logic              scsi_irq,
    output logic              engine_en,
    output logic              abort_pulse
);

    localparam int NPROG = 3;

    logic [DATA_W-1:0] prog_q [NPROG];
    logic [DATA_W-1:0] cmd_q, wcnt, wadr, wlst;
    logic [STAT_W-1:0] stat_q, stat_view;
    logic              start_ld, cmd_wr, st_wr, st_rd;

    // Port decode for the command and status words.
    always_comb begin
        cmd_wr  = reg_wr && (reg_idx == RI_CMD);
        st_wr   = reg_wr && (reg_idx == RI_STAT);
        st_rd   = reg_rd && (reg_idx == RI_STAT);
        xfer_ok = xfer_req && (xfer_to_mem == cmd_q[CMD_DIR_BIT]);
    end

    // Start copies: count, address and list address, one register each.
    for (genvar gi = 0; gi < NPROG; gi++) begin : g_prog
        localparam logic [IDX_W-1:0] MY_IDX =
            (gi == 0) ? RI_SCNT : (gi == 1) ? RI_SADR : RI_SLST;
        // Store on a write to this word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prog_q[gi] <= '0;
            else if (reg_wr && (reg_idx == MY_IDX))
                prog_q[gi] <= reg_wdata;
        end
    end

    dma_cmd_ctl #(.DATA_W(DATA_W)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .wdata       (reg_wdata),
        .cmd_q       (cmd_q),
        .start_ld    (start_ld),
        .engine_en   (engine_en),
        .abort_pulse (abort_pulse)
    );

    dma_work_ctr #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_work (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ld),
        .ld_cnt     (prog_q[0]),
        .ld_adr     (prog_q[1]),
        .ld_lst     (prog_q[2]),
        .xfer_fire  (xfer_ok),
        .xfer_len   (xfer_len),
        .cmd_done   (cmd_done),
        .wcnt       (wcnt),
        .wadr       (wadr),
        .wlst       (wlst),
        .xfer_bytes (xfer_bytes)
    );

    dma_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_clr   (start_ld),
        .st_wr       (st_wr),
        .st_wdata    (reg_wdata[STAT_W-1:0]),
        .st_rd       (st_rd),
        .clr_on_read (clr_on_read),
        .set_done    (cmd_done),
        .stat_q      (stat_q)
    );

    // Read mux with the live interrupt merged into the status view.
    always_comb begin
        stat_view         = stat_q;
        stat_view[ST_IRQ] = stat_q[ST_IRQ] | scsi_irq;
        case (reg_idx_e'(reg_idx))
            RI_CMD:  reg_rdata = cmd_q;
            RI_SCNT: reg_rdata = prog_q[0];
            RI_SADR: reg_rdata = prog_q[1];
            RI_WCNT: reg_rdata = wcnt;
            RI_WADR: reg_rdata = wadr;
            RI_STAT: reg_rdata = DATA_W'(stat_view);
            RI_SLST: reg_rdata = prog_q[2];
            default: reg_rdata = wlst;
        endcase
    end

    AST_WRONG_DIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ok && !start_ld && !cmd_done)
        |=> ($stable(wcnt) && $stable(wadr))); // R10
    AST_IRQ_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi_irq && reg_idx == 3'd5) |-> reg_rdata[4]); // R8

endmodule

// File: tb/tb_scsi_dma_chan.sv
module tb_scsi_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clr_on_read = 1'b0;
    logic        xfer_req = 1'b0, xfer_to_mem = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        xfer_ok;
    logic [31:0] xfer_bytes;
    logic        cmd_done = 1'b0, scsi_irq = 1'b0;
    logic        engine_en, abort_pulse;

    always #2 clk = ~clk;

    scsi_dma_chan dut (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench model
    logic [31:0] m_cmd, m_scnt, m_sadr, m_slst, m_wcnt, m_wadr, m_wlst;
    logic [5:0]  m_stat;
    logic        m_en;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] idx, input logic irq);
        case (idx)
            3'd0: return m_cmd;
            3'd1: return m_scnt;
            3'd2: return m_sadr;
            3'd3: return m_wcnt;
            3'd4: return m_wadr;
            3'd5: return {26'd0, m_stat[5], m_stat[4] | irq, m_stat[3:0]};
            3'd6: return m_slst;
            default: return m_wlst;
        endcase
    endfunction

    function automatic logic [31:0] exp_grant(input logic [15:0] len);
        logic [31:0] l = {16'd0, len};
        return (l < m_wcnt) ? l : m_wcnt;
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_scnt = 0; m_sadr = 0; m_slst = 0; m_wcnt = 0;
        m_wadr = 32'hFFFF_FFFF; m_wlst = 32'hFFFF_FFFD; m_stat = 0; m_en = 0;
    endtask

    task automatic post_checks(input bit exp_abort, input string tag);
        chk(abort_pulse == exp_abort, {tag, " R4 abort_pulse"}, 32'(abort_pulse), 32'(exp_abort));
        chk(engine_en == m_en, {tag, " R3 engine_en"}, 32'(engine_en), 32'(m_en));
    endtask

    task automatic do_write(input logic [2:0] idx, input logic [31:0] v);
        bit ab = 0;
        reg_wr = 1; reg_idx = idx; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
        case (idx)
            3'd0: begin
                m_cmd = v;
                case (v[1:0])
                    2'd0: m_en = 0;
                    2'd2: ab = 1;
                    2'd3: begin
                        m_wcnt = m_scnt; m_wadr = m_sadr; m_wlst = m_slst;
                        m_stat = 0; m_en = 1;
                    end
                    default: ;
                endcase
            end
            3'd1: m_scnt = v;
            3'd2: m_sadr = v;
            3'd6: m_slst = v;
            3'd5: if (!clr_on_read) m_stat = m_stat & ~(v[5:0] & 6'b001110);
            default: ;
        endcase
        post_checks(ab, "write R2 R5");
    endtask

    task automatic do_read(input logic [2:0] idx, input logic irq, input string tag);
        logic [31:0] e;
        reg_rd = 1; reg_idx = idx; scsi_irq = irq;
        #1;
        e = exp_read(idx, irq);
        chk(reg_rdata == e, tag, reg_rdata, e);
        @(negedge clk);
        reg_rd = 0; scsi_irq = 0;
        if (idx == 3'd5 && clr_on_read) m_stat = m_stat & ~6'b001110;
        post_checks(0, "read");
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) do_read(3'(i), 1'b0, tag);
    endtask

    task automatic do_xfer(input logic [15:0] len, input logic dir);
        bit ok;
        logic [31:0] g;
        xfer_req = 1; xfer_len = len; xfer_to_mem = dir;
        #1;
        ok = (dir == m_cmd[7]);
        g = ok ? exp_grant(len) : 32'd0;
        chk(xfer_ok == ok, "R10 xfer_ok", 32'(xfer_ok), 32'(ok));
        chk(xfer_bytes == g, "R9 R10 xfer_bytes", xfer_bytes, g);
        @(negedge clk);
        xfer_req = 0;
        if (ok) begin
            m_wcnt = m_wcnt - g; m_wadr = m_wadr + g;
        end
        post_checks(0, "xfer");
    endtask

    task automatic do_done();
        cmd_done = 1;
        @(negedge clk);
        cmd_done = 0;
        m_wcnt = 0; m_stat[3] = 1;
        post_checks(0, "R11 done");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        post_checks(0, "R1 reset");
        read_all("R1 reset word");

        // R2: working words not writable; programmable words are
        do_write(3'd3, 32'h1234); do_write(3'd4, 32'h5678); do_write(3'd7, 32'h9ABC);
        do_write(3'd1, 32'd100); do_write(3'd2, 32'h0000_1000); do_write(3'd6, 32'h0000_2000);
        read_all("R2 writable map");

        // R5: start toward memory
        do_write(3'd0, 32'h0000_0083);
        read_all("R5 start load");

        // R9: clipping
        do_xfer(16'd40, 1'b1);
        do_xfer(16'd80, 1'b1);
        do_xfer(16'd5, 1'b1);
        do_read(3'd3, 1'b0, "R9 count exhausted");
        do_read(3'd4, 1'b0, "R9 address advanced");
        // R10: wrong direction
        do_write(3'd0, 32'h0000_0003);
        do_xfer(16'd7, 1'b1);
        read_all("R10 no change");

        // R11, R8, R6
        do_done();
        do_read(3'd5, 1'b0, "R11 done flag");
        do_read(3'd3, 1'b0, "R11 count zero");
        do_read(3'd5, 1'b1, "R8 live irq");
        do_write(3'd5, 32'h0000_0008);
        do_read(3'd5, 1'b0, "R6 write one clears");
        // R7
        do_done();
        clr_on_read = 1;
        do_write(3'd5, 32'h0000_000E);
        do_read(3'd5, 1'b0, "R7 write ignored then read");
        do_read(3'd5, 1'b0, "R7 cleared by read");
        clr_on_read = 0;

        // R4, R3
        do_write(3'd0, 32'h0000_0002);
        do_write(3'd0, 32'h0000_0001);
        read_all("R3 flush no change");
        do_write(3'd0, 32'h0000_0000);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 12;
            case (r)
                0: do_write(3'd1, $urandom % 1200);
                1: do_write(3'd0, {24'd0, 1'($urandom), 5'($urandom), 2'($urandom)});
                2: do_write(3'($urandom), $urandom);
                3, 4: do_read(3'($urandom), 1'($urandom), "R2 R8 random read");
                5, 6, 7: do_xfer(16'($urandom % 400), 1'($urandom));
                8: if ($urandom % 3 == 0) do_done(); else do_read(3'd5, 1'b0, "R11 random status");
                9: clr_on_read = 1'($urandom);
                10: do_write(3'd5, $urandom);
                default: do_write(3'(($urandom % 2) ? 2 : 6), $urandom);
            endcase
        end
        read_all("R9 final state");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule